// File: doc/BRIEF.md
# Dual-Port Memory with Mailbox Interrupts

This block is a 1K x 8 dual-port memory whose two sides, called left and right, each have their own chip enable, output enable, write strobe, address, write data, read data and busy input. Both sides may read or write any location in the same clock cycle. Read data is registered and appears one cycle after the read. A busy input, driven by an external arbiter, stops its own side's writes.

The two highest addresses double as mailboxes. The highest address belongs to the right side and the one below it belongs to the left side. When one side writes into the other side's mailbox, the receiving side's active-low interrupt output goes low. The receiving side clears it by selecting its own mailbox with chip enable and output enable active. The bytes in both mailboxes remain ordinary storage. A parameter removes the interrupt function, so that both addresses become plain memory and both interrupt outputs stay high.

Top module: `mbox_dpram`

## Requirements
- R1: After reset both interrupt outputs (`lIntN`, `rIntN`) are high and both read data outputs are zero.
- R2: A side writes when its chip enable and write strobe are high and its busy input is low. A side reads when chip enable and output enable are high and the write strobe is low. Read data appears on the next cycle. A read in the same cycle as a write to the same address by the other side returns the byte stored before that cycle.
- R3: A write attempt with chip enable low, or with that side's busy input high, leaves the memory unchanged.
- R4: A left write to address 0x3FF drives `rIntN` low on the next cycle.
- R5: A right write to address 0x3FE drives `lIntN` low on the next cycle.
- R6: With the right chip enable and output enable high at address 0x3FF and right busy low, `rIntN` returns high on the next cycle, whatever the right write strobe is.
- R7: With the left chip enable and output enable high at address 0x3FE and left busy low, `lIntN` returns high on the next cycle, whatever the left write strobe is.
- R8: A set or clear whose acting side has its busy input high does not happen. The interrupt output keeps its value.
- R9: When a set and a clear of the same flag fall in one cycle, the set wins and the output is low on the next cycle.
- R10: The bytes at 0x3FE and 0x3FF are stored and read back like any other location.
- R11: With `MBOX_EN` = 0, both interrupt outputs stay high under any access, and addresses 0x3FE and 0x3FF act as plain memory.
- R12: When both sides write the same address in one cycle, the left data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lCs | input | 1 | Left chip enable |
| lOe | input | 1 | Left output enable |
| lWe | input | 1 | Left write strobe |
| lBusy | input | 1 | Left busy; blocks left writes and left flag actions |
| lAddr | input | 10 | Left address |
| lWdata | input | 8 | Left write data |
| lRdata | output | 8 | Left read data, registered |
| lIntN | output | 1 | Left interrupt, active low |
| rCs | input | 1 | Right chip enable |
| rOe | input | 1 | Right output enable |
| rWe | input | 1 | Right write strobe |
| rBusy | input | 1 | Right busy; blocks right writes and right flag actions |
| rAddr | input | 10 | Right address |
| rWdata | input | 8 | Right write data |
| rRdata | output | 8 | Right read data, registered |
| rIntN | output | 1 | Right interrupt, active low |

## Verification
The set and the clear of the left flag can fall in the same cycle. The bench provokes this by having the left side read its mailbox while the right side writes that same mailbox. It judges the cycle by `lIntN` being low afterwards and by the left read returning the byte stored before the write. A following plain left read of the mailbox must then return the new byte and release `lIntN`. The bench also checks that busy blocks a clear and a set while the other flag actions go through.

// File: rtl/mbox_dpram_pkg.sv
`timescale 1ns/1ps
package mbox_dpram_pkg;
  // Qualified per-side memory strobes, decoded by control, consumed by datapath
  typedef struct packed {
    logic lWr;
    logic rWr;
    logic lRd;
    logic rRd;
  } memStrobe_t;
endpackage

// File: rtl/mbox_dpram_ctrl.sv
`timescale 1ns/1ps
module mbox_dpram_ctrl
  import mbox_dpram_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter bit MBOX_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lCs,
  input  logic              lOe,
  input  logic              lWe,
  input  logic              lBusy,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              rCs,
  input  logic              rOe,
  input  logic              rWe,
  input  logic              rBusy,
  input  logic [ADDR_W-1:0] rAddr,
  output memStrobe_t        strobe,
  output logic              lFlag,
  output logic              rFlag
);
  // Right mailbox is the top address, left mailbox the one below
  localparam logic [ADDR_W-1:0] R_BOX = '1;
  localparam logic [ADDR_W-1:0] L_BOX = R_BOX - 1'b1;

  always_comb begin
    strobe.lWr = lCs & lWe & ~lBusy;
    strobe.rWr = rCs & rWe & ~rBusy;
    strobe.lRd = lCs & lOe & ~lWe;
    strobe.rRd = rCs & rOe & ~rWe;
  end

  generate
    if (MBOX_EN) begin : g_mbox
      logic lSet, lClr, rSet, rClr;
      // Set comes from the opposite side's write, clear from the owner's select
      assign rSet = strobe.lWr & (lAddr == R_BOX);
      assign lSet = strobe.rWr & (rAddr == L_BOX);
      assign rClr = rCs & rOe & ~rBusy & (rAddr == R_BOX);
      assign lClr = lCs & lOe & ~lBusy & (lAddr == L_BOX);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          lFlag <= 1'b0;
          rFlag <= 1'b0;
        end else begin
          if (lSet)      lFlag <= 1'b1;
          else if (lClr) lFlag <= 1'b0;
          if (rSet)      rFlag <= 1'b1;
          else if (rClr) rFlag <= 1'b0;
        end
      end
    end else begin : g_plain
      assign lFlag = 1'b0;
      assign rFlag = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/mbox_dpram_data.sv
`timescale 1ns/1ps
module mbox_dpram_data
  import mbox_dpram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWdata,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWdata,
  output logic [DATA_W-1:0] lRdata,
  output logic [DATA_W-1:0] rRdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Left update is written last so it wins a same-address collision
  always_ff @(posedge clk) begin
    if (strobe.rWr) mem[rAddr] <= rWdata;
    if (strobe.lWr) mem[lAddr] <= lWdata;
  end

  // Registered reads see the content from before this edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lRdata <= '0;
      rRdata <= '0;
    end else begin
      if (strobe.lRd) lRdata <= mem[lAddr];
      if (strobe.rRd) rRdata <= mem[rAddr];
    end
  end
endmodule

// File: rtl/mbox_dpram.sv
`timescale 1ns/1ps
module mbox_dpram
  import mbox_dpram_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 8,
  parameter bit MBOX_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lCs,
  input  logic              lOe,
  input  logic              lWe,
  input  logic              lBusy,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWdata,
  output logic [DATA_W-1:0] lRdata,
  output logic              lIntN,
  input  logic              rCs,
  input  logic              rOe,
  input  logic              rWe,
  input  logic              rBusy,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWdata,
  output logic [DATA_W-1:0] rRdata,
  output logic              rIntN
);
  memStrobe_t strobe;
  logic       lFlag, rFlag;

  mbox_dpram_ctrl #(.ADDR_W(ADDR_W), .MBOX_EN(MBOX_EN)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .lCs(lCs), .lOe(lOe), .lWe(lWe), .lBusy(lBusy), .lAddr(lAddr),
    .rCs(rCs), .rOe(rOe), .rWe(rWe), .rBusy(rBusy), .rAddr(rAddr),
    .strobe(strobe), .lFlag(lFlag), .rFlag(rFlag)
  );

  mbox_dpram_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lAddr(lAddr), .lWdata(lWdata), .rAddr(rAddr), .rWdata(rWdata),
    .lRdata(lRdata), .rRdata(rRdata)
  );

  assign lIntN = ~lFlag;
  assign rIntN = ~rFlag;
endmodule

// File: rtl/mbox_dpram_chk.sv
`timescale 1ns/1ps
module mbox_dpram_chk #(
  parameter int ADDR_W  = 10,
  parameter bit MBOX_EN = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              lCs,
  input logic              lOe,
  input logic              lWe,
  input logic              lBusy,
  input logic [ADDR_W-1:0] lAddr,
  input logic              lIntN,
  input logic              rCs,
  input logic              rOe,
  input logic              rWe,
  input logic              rBusy,
  input logic [ADDR_W-1:0] rAddr,
  input logic              rIntN
);
  localparam logic [ADDR_W-1:0] R_BOX = '1;
  localparam logic [ADDR_W-1:0] L_BOX = R_BOX - 1'b1;

  logic rSetIn, lSetIn, rClrIn, lClrIn;
  assign rSetIn = lCs && lWe && !lBusy && (lAddr == R_BOX);
  assign lSetIn = rCs && rWe && !rBusy && (rAddr == L_BOX);
  assign rClrIn = rCs && rOe && !rBusy && (rAddr == R_BOX);
  assign lClrIn = lCs && lOe && !lBusy && (lAddr == L_BOX);

  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (lIntN && rIntN));

  generate
    if (MBOX_EN) begin : g_on
      p_set_right_r4: assert property (@(posedge clk) disable iff (!rstN)
        rSetIn |=> !rIntN);
      p_set_left_r5: assert property (@(posedge clk) disable iff (!rstN)
        lSetIn |=> !lIntN);
      p_clr_right_r6: assert property (@(posedge clk) disable iff (!rstN)
        (rClrIn && !rSetIn) |=> rIntN);
      p_clr_left_r7: assert property (@(posedge clk) disable iff (!rstN)
        (lClrIn && !lSetIn) |=> lIntN);
      p_hold_right_r8: assert property (@(posedge clk) disable iff (!rstN)
        (!rSetIn && !rClrIn) |=> $stable(rIntN));
      p_hold_left_r8: assert property (@(posedge clk) disable iff (!rstN)
        (!lSetIn && !lClrIn) |=> $stable(lIntN));
    end else begin : g_off
      p_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
        rSetIn || lSetIn |=> (lIntN && rIntN));
    end
  endgenerate
endmodule

bind mbox_dpram mbox_dpram_chk #(.ADDR_W(ADDR_W), .MBOX_EN(MBOX_EN)) u_chk (
  .clk(clk), .rstN(rstN),
  .lCs(lCs), .lOe(lOe), .lWe(lWe), .lBusy(lBusy), .lAddr(lAddr), .lIntN(lIntN),
  .rCs(rCs), .rOe(rOe), .rWe(rWe), .rBusy(rBusy), .rAddr(rAddr), .rIntN(rIntN)
);

// File: tb/mbox_dpram_tb.sv
`timescale 1ns/1ps
module mbox_dpram_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lCs = 0, lOe = 0, lWe = 0, lBusy = 0;
  logic rCs = 0, rOe = 0, rWe = 0, rBusy = 0;
  logic [9:0] lAddr = '0, rAddr = '0;
  logic [7:0] lWdata = '0, rWdata = '0;
  logic [7:0] lRdata, rRdata, oLRdata, oRRdata;
  logic lIntN, rIntN, oLIntN, oRIntN;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mbox_dpram u_dut (
    .clk(clk), .rstN(rstN),
    .lCs(lCs), .lOe(lOe), .lWe(lWe), .lBusy(lBusy), .lAddr(lAddr),
    .lWdata(lWdata), .lRdata(lRdata), .lIntN(lIntN),
    .rCs(rCs), .rOe(rOe), .rWe(rWe), .rBusy(rBusy), .rAddr(rAddr),
    .rWdata(rWdata), .rRdata(rRdata), .rIntN(rIntN)
  );

  mbox_dpram #(.MBOX_EN(1'b0)) u_off (
    .clk(clk), .rstN(rstN),
    .lCs(lCs), .lOe(lOe), .lWe(lWe), .lBusy(lBusy), .lAddr(lAddr),
    .lWdata(lWdata), .lRdata(oLRdata), .lIntN(oLIntN),
    .rCs(rCs), .rOe(rOe), .rWe(rWe), .rBusy(rBusy), .rAddr(rAddr),
    .rWdata(rWdata), .rRdata(oRRdata), .rIntN(oRIntN)
  );

  typedef struct {
    bit         isLeft;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: reads issued before a rising edge are compared at the next falling edge
  initial forever begin
    int nDue;
    @(posedge clk);
    nDue = q.size();
    @(negedge clk);
    #1;
    repeat (nDue) begin
      item_t it;
      it = q.pop_front();
      chk(it.tag, it.isLeft ? lRdata : rRdata, it.exp);
    end
  end

  task automatic setL(logic cs, logic oe, logic we, logic busy, logic [9:0] a, logic [7:0] d);
    lCs = cs; lOe = oe; lWe = we; lBusy = busy; lAddr = a; lWdata = d;
  endtask
  task automatic setR(logic cs, logic oe, logic we, logic busy, logic [9:0] a, logic [7:0] d);
    rCs = cs; rOe = oe; rWe = we; rBusy = busy; rAddr = a; rWdata = d;
  endtask
  task automatic idle();
    setL(0, 0, 0, 0, '0, '0);
    setR(0, 0, 0, 0, '0, '0);
  endtask
  task automatic expectRd(bit isLeft, logic [7:0] exp, string tag);
    item_t it;
    it.isLeft = isLeft; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask
  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 lIntN", lIntN, 1); chk("R1 rIntN", rIntN, 1);
    chk("R1 lRdata", lRdata, 0); chk("R1 rRdata", rRdata, 0);

    // R2 basic writes then cross reads
    setL(1, 0, 1, 0, 10'h012, 8'hA5); setR(1, 0, 1, 0, 10'h200, 8'h3C); step();
    setL(1, 1, 0, 0, 10'h200, 0); setR(1, 1, 0, 0, 10'h012, 0);
    expectRd(1, 8'h3C, "R2 left read"); expectRd(0, 8'hA5, "R2 right read"); step();

    // R3 busy and deselected writes are dropped
    setL(1, 0, 1, 1, 10'h012, 8'hFF); idleR(); step();
    setL(0, 0, 1, 0, 10'h012, 8'h00); step();
    idle(); setR(1, 1, 0, 0, 10'h012, 0); expectRd(0, 8'hA5, "R3 blocked write"); step();

    // R12 collision: left data kept
    setL(1, 0, 1, 0, 10'h055, 8'h11); setR(1, 0, 1, 0, 10'h055, 8'h22); step();
    idle(); setL(1, 1, 0, 0, 10'h055, 0); expectRd(1, 8'h11, "R12 collision"); step();

    // R4 left writes right mailbox
    idle(); setL(1, 0, 1, 0, 10'h3FF, 8'h77); step();
    chk("R4 rIntN", rIntN, 0); chk("R4 lIntN", lIntN, 1);
    chk("R11 off rIntN", oRIntN, 1);

    // R8 clear blocked by right busy; R10 mailbox readable
    idle(); setR(1, 1, 0, 1, 10'h3FF, 0); expectRd(0, 8'h77, "R10 read 3FF"); step();
    chk("R8 clear blocked", rIntN, 0);

    // R6 clear with write strobe high (also stores 99)
    idle(); setR(1, 1, 1, 0, 10'h3FF, 8'h99); step();
    chk("R6 rIntN cleared", rIntN, 1);
    idle(); setR(1, 1, 0, 0, 10'h3FF, 0); expectRd(0, 8'h99, "R10 rewrite 3FF"); step();

    // R8 set blocked by left busy
    idle(); setL(1, 0, 1, 1, 10'h3FF, 8'h44); step();
    chk("R8 set blocked", rIntN, 1);

    // R5 right writes left mailbox
    idle(); setR(1, 0, 1, 0, 10'h3FE, 8'h5A); step();
    chk("R5 lIntN", lIntN, 0); chk("R11 off lIntN", oLIntN, 1);

    // R7 left reads its mailbox
    idle(); setL(1, 1, 0, 0, 10'h3FE, 0); expectRd(1, 8'h5A, "R10 read 3FE"); step();
    chk("R7 lIntN cleared", lIntN, 1);

    // R9 set and clear together: set wins, read sees old byte
    setL(1, 1, 0, 0, 10'h3FE, 0); setR(1, 0, 1, 0, 10'h3FE, 8'h6B);
    expectRd(1, 8'h5A, "R9 old byte"); step();
    chk("R9 set wins", lIntN, 0);
    idle(); setL(1, 1, 0, 0, 10'h3FE, 0); expectRd(1, 8'h6B, "R9 new byte"); step();
    chk("R7 clear after R9", lIntN, 1);
    chk("R11 off plain 3FE", oLRdata, 8'h6B);
    chk("R11 off lIntN end", oLIntN, 1); chk("R11 off rIntN end", oRIntN, 1);

    idle(); step(); step();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic idleR();
    setR(0, 0, 0, 0, '0, '0);
  endtask
endmodule